// File: doc/BRIEF.md
# Two-Stage Peripheral Clock-Enable Generator

This block turns one of three PLL-rate strobes into a divided peripheral clock enable. A 2-bit source code picks the strobe. The strobe passes through two cascaded programmable dividers, so the second divider counts the pulses that come out of the first. After the dividers, a bypass switch can replace the divided pulse with an external strobe. One or two output gates then pass the pulse on. Every clock is modelled as a single-cycle enable pulse in the reference clock domain, and the external input is a synchronous strobe.

Software writes a 32-bit control word and a separate gate word through a plain write port, and reads either word back through a combinational read port. Two parameters set which gating scheme an instance uses. With `SEP_GATE=0`, control bits 0 and 1 enable outputs 0 and 1; `TWO_OUT=0` holds output 1 low. With `SEP_GATE=1`, output 0 is disabled while bit 0 of the gate word is 1, output 1 stays low, and control bits 0 and 1 have no effect. `INIT_EN` sets the reset value of the gate word's bit 0 to the inverse of `INIT_EN`, which gives each instance its own initial enable. All inputs are strobes or plain control pins. There is no valid/ready handshake, so nothing is ever held back: a strobe that arrives is counted in that cycle.

Top module: `pclk_gen`

## Requirements
- R1: While reset is asserted, the control word reads 0, the gate word reads `{31'b0, !INIT_EN}`, and both outputs are 0.
- R2: Source code ctrl[5:4] selects the strobe: codes 0 and 1 select `pll_io_tick`, code 2 selects `pll_cpu_tick`, and code 3 selects `pll_mem_tick`.
- R3: The first divider's divisor is ctrl[13:8]. It emits one pulse per divisor source strobes, and the pulse coincides with the last strobe counted. A divisor of 0 behaves as 1.
- R4: The second divider's divisor is ctrl[25:20]. It counts pulses from the first divider in the same way, with 0 treated as 1, so the overall ratio is the product of the two divisors.
- R5: When ctrl[6] is 1, the gated pulse is `ext_tick` instead of the second divider's output. When ctrl[6] is 0, the second divider's output is used.
- R6: A control write that changes either divisor field clears both divider counts at that edge. A control write that leaves both divisor fields unchanged does not disturb the counts.
- R7: With `SEP_GATE=0`, ctrl[0] gates output 0 and ctrl[1] gates output 1 (1 means pass). Output 1 exists only when `TWO_OUT=1`.
- R8: With `SEP_GATE=1`, gate-word bit 0 equal to 1 disables output 0, output 1 is always 0, and ctrl[1:0] are ignored.
- R9: `reg_rdata` returns the last value written to the word named by `reg_rsel` (0 = control, 1 = gate), with all 32 bits kept.
- R10: Each output is registered. A pulse selected and gated in cycle n appears on `clk_en_o` in cycle n+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_io_tick | input | 1 | I/O PLL strobe |
| pll_cpu_tick | input | 1 | CPU PLL strobe |
| pll_mem_tick | input | 1 | Memory PLL strobe |
| ext_tick | input | 1 | External clock strobe for bypass |
| reg_we | input | 1 | Write strobe |
| reg_sel | input | 1 | Write target: 0 control word, 1 gate word |
| reg_wdata | input | 32 | Write data |
| reg_rsel | input | 1 | Read target: 0 control word, 1 gate word |
| reg_rdata | output | 32 | Read data |
| clk_en_o | output | 2 | Registered clock-enable pulses for outputs 0 and 1 |

## Verification
The bench builds two instances that share one stimulus. The first uses `SEP_GATE=0`, `TWO_OUT=1`, `INIT_EN=0`, which exercises both control-bit gates. The second uses `SEP_GATE=1`, `TWO_OUT=0`, `INIT_EN=1`, which exercises the inverted gate word and a non-zero reset enable. Because the bus is shared, every gate-word write tests that the word has no effect on the first instance. Every control-gate change tests that the control gate bits are ignored by the second instance. The default 6-bit divisor width lets the bench reach divisors of 0 and 1, mixed products, and mid-count divisor changes within a few hundred cycles.

// File: rtl/pclk_pkg.sv
`timescale 1ns/1ps
package pclk_pkg;
  localparam int WORD_W   = 32;
  localparam int SRC_LO   = 4;
  localparam int BYP_BIT  = 6;
  localparam int DIV1_LO  = 8;
  localparam int DIV2_LO  = 20;
  localparam int N_STAGES = 2;
  localparam int N_OUT    = 2;

  typedef enum logic [1:0] {
    SRC_IO_A = 2'd0,
    SRC_IO_B = 2'd1,
    SRC_CPU  = 2'd2,
    SRC_MEM  = 2'd3
  } src_sel_e;
endpackage

// File: rtl/pclk_divstage.sv
`timescale 1ns/1ps
module pclk_divstage #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         tick_in,
  input  logic [W-1:0] div_val,
  output logic         tick_out
);
  logic [W-1:0] cnt;
  logic [W-1:0] last;

  assign last     = (div_val == '0) ? '0 : div_val - W'(1);
  assign tick_out = tick_in && (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (tick_in) cnt <= tick_out ? '0 : cnt + W'(1);
  end

  // R3: the count never passes the effective terminal value
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= last);

  // R6: a restart leaves the count cleared
  p_restart_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> cnt == '0);

  // R4: a stage that emits a pulse starts counting again from zero
  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tick_out |=> cnt == '0);
endmodule

// File: rtl/pclk_regs.sv
`timescale 1ns/1ps
module pclk_regs
  import pclk_pkg::*;
#(
  parameter int DIV_W   = 6,
  parameter bit INIT_EN = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              sel,
  input  logic [WORD_W-1:0] wdata,
  input  logic              rsel,
  output logic [WORD_W-1:0] ctrl_q,
  output logic [WORD_W-1:0] gate_q,
  output logic [WORD_W-1:0] rdata,
  output logic              div_changed
);
  localparam logic [WORD_W-1:0] GATE_RST = WORD_W'(!INIT_EN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      gate_q <= GATE_RST;
    end else if (we) begin
      if (sel) gate_q <= wdata;
      else     ctrl_q <= wdata;
    end
  end

  assign div_changed = we && !sel &&
    ((wdata[DIV1_LO +: DIV_W] != ctrl_q[DIV1_LO +: DIV_W]) ||
     (wdata[DIV2_LO +: DIV_W] != ctrl_q[DIV2_LO +: DIV_W]));

  assign rdata = rsel ? gate_q : ctrl_q;

  // R9: a control write is held exactly
  p_ctrl_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !sel) |=> ctrl_q == $past(wdata));

  // R9: a gate write is held exactly
  p_gate_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel) |=> gate_q == $past(wdata));

  // R9: no write leaves both words stable
  p_idle_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> ($stable(ctrl_q) && $stable(gate_q)));
endmodule

// File: rtl/pclk_gen.sv
`timescale 1ns/1ps
module pclk_gen
  import pclk_pkg::*;
#(
  parameter int DIV_W    = 6,
  parameter bit TWO_OUT  = 1'b1,
  parameter bit SEP_GATE = 1'b0,
  parameter bit INIT_EN  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pll_io_tick,
  input  logic              pll_cpu_tick,
  input  logic              pll_mem_tick,
  input  logic              ext_tick,
  input  logic              reg_we,
  input  logic              reg_sel,
  input  logic [WORD_W-1:0] reg_wdata,
  input  logic              reg_rsel,
  output logic [WORD_W-1:0] reg_rdata,
  output logic [N_OUT-1:0]  clk_en_o
);
  localparam int DIV_LO [N_STAGES] = '{DIV1_LO, DIV2_LO};

  logic [WORD_W-1:0] ctrl_q, gate_q;
  logic              div_changed;
  src_sel_e          src_sel;
  logic              src_tick;
  logic              bypass;
  logic              pulse;
  logic [N_OUT-1:0]  gate_vec;
  logic [N_STAGES:0] chain;

  pclk_regs #(.DIV_W(DIV_W), .INIT_EN(INIT_EN)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (reg_we),
    .sel        (reg_sel),
    .wdata      (reg_wdata),
    .rsel       (reg_rsel),
    .ctrl_q     (ctrl_q),
    .gate_q     (gate_q),
    .rdata      (reg_rdata),
    .div_changed(div_changed)
  );

  assign src_sel = src_sel_e'(ctrl_q[SRC_LO +: 2]);
  assign bypass  = ctrl_q[BYP_BIT];

  always_comb begin
    unique case (src_sel)
      SRC_CPU: src_tick = pll_cpu_tick;
      SRC_MEM: src_tick = pll_mem_tick;
      default: src_tick = pll_io_tick;
    endcase
  end

  assign chain[0] = src_tick;

  for (genvar s = 0; s < N_STAGES; s++) begin : g_stage
    pclk_divstage #(.W(DIV_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (div_changed),
      .tick_in (chain[s]),
      .div_val (ctrl_q[DIV_LO[s] +: DIV_W]),
      .tick_out(chain[s+1])
    );
  end

  assign pulse = bypass ? ext_tick : chain[N_STAGES];

  if (SEP_GATE) begin : g_sep_gate
    assign gate_vec = {1'b0, !gate_q[0]};
  end else if (TWO_OUT) begin : g_two_gate
    assign gate_vec = ctrl_q[1:0];
  end else begin : g_one_gate
    assign gate_vec = {1'b0, ctrl_q[0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk_en_o <= '0;
    else        clk_en_o <= {N_OUT{pulse}} & gate_vec;
  end

  // R7: an output pulses only if its gate was open in the cycle before
  p_gate_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_o[0] |-> $past(gate_vec[0]));

  // R8: the second output stays low in the separate-gate variant
  p_single_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (SEP_GATE || !TWO_OUT) |-> !clk_en_o[1]);

  // R5: in bypass, a missing external strobe gives no output pulse
  p_bypass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bypass && !ext_tick) |-> clk_en_o == '0);

  // R10: an output pulse needs a selected pulse one cycle earlier
  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en_o != '0) |-> $past(pulse));
endmodule

// File: tb/sim_pclk_gen.sv
`timescale 1ns/1ps
module sim_pclk_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic io_t = 1'b0, cpu_t = 1'b0, mem_t = 1'b0, ext_t = 1'b0;
  logic we = 1'b0, wsel = 1'b0, rsel = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rd0, rd1;
  logic [1:0]  en0, en1;

  int compared = 0;
  int mismatched = 0;
  string cur_req = "R1";
  bit done = 1'b0;
  int k = 0;

  always #2.5 clk = ~clk;

  pclk_gen #(.DIV_W(6), .TWO_OUT(1'b1), .SEP_GATE(1'b0), .INIT_EN(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .pll_io_tick(io_t), .pll_cpu_tick(cpu_t),
    .pll_mem_tick(mem_t), .ext_tick(ext_t), .reg_we(we), .reg_sel(wsel),
    .reg_wdata(wdata), .reg_rsel(rsel), .reg_rdata(rd0), .clk_en_o(en0));

  pclk_gen #(.DIV_W(6), .TWO_OUT(1'b0), .SEP_GATE(1'b1), .INIT_EN(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .pll_io_tick(io_t), .pll_cpu_tick(cpu_t),
    .pll_mem_tick(mem_t), .ext_tick(ext_t), .reg_we(we), .reg_sel(wsel),
    .reg_wdata(wdata), .reg_rsel(rsel), .reg_rdata(rd1), .clk_en_o(en1));

  // Strobe patterns and read select, driven away from the active edge
  always @(negedge clk) begin
    k = k + 1;
    io_t  = 1'b1;
    cpu_t = (k % 2) == 0;
    mem_t = (k % 3) == 1;
    ext_t = (k % 7) == 3;
    rsel  = k[0];
  end

  // Behavioural reference model
  int c1 = 0, c2 = 0;
  logic [31:0] m_ctrl = '0;
  logic [31:0] m_gate [2];
  logic [1:0]  m_en [2];

  always @(posedge clk) begin
    if (!rst_n) begin
      c1 = 0; c2 = 0; m_ctrl = '0;
      m_gate[0] = 32'd1; m_gate[1] = 32'd0;
      m_en[0] = 2'b00; m_en[1] = 2'b00;
    end else begin
      int d1, d2;
      bit src, t1, t2, m, rst_cnt;
      case (m_ctrl[5:4])
        2'd2:    src = cpu_t;
        2'd3:    src = mem_t;
        default: src = io_t;
      endcase
      d1 = int'(m_ctrl[13:8]);  if (d1 == 0) d1 = 1;
      d2 = int'(m_ctrl[25:20]); if (d2 == 0) d2 = 1;
      t1 = src && (c1 == d1 - 1);
      t2 = t1 && (c2 == d2 - 1);
      m  = m_ctrl[6] ? ext_t : t2;
      m_en[0] = {m && m_ctrl[1], m && m_ctrl[0]};
      m_en[1] = {1'b0, m && !m_gate[1][0]};
      rst_cnt = we && !wsel &&
                ((wdata[13:8] != m_ctrl[13:8]) || (wdata[25:20] != m_ctrl[25:20]));
      if (rst_cnt) begin
        c1 = 0; c2 = 0;
      end else begin
        if (src) c1 = t1 ? 0 : c1 + 1;
        if (t1)  c2 = t2 ? 0 : c2 + 1;
      end
      if (we) begin
        if (wsel) begin m_gate[0] = wdata; m_gate[1] = wdata; end
        else      m_ctrl = wdata;
      end
    end
  end

  task automatic check_inst(input int idx, input logic [1:0] got_en,
                            input logic [31:0] got_rd);
    logic [31:0] exp_rd;
    exp_rd = rsel ? m_gate[idx] : m_ctrl;
    compared++;
    if (got_en !== m_en[idx] || got_rd !== exp_rd) begin
      mismatched++;
      $display("FAIL %s inst %0d en got %b exp %b rdata got %h exp %h (t=%0t)",
               cur_req, idx, got_en, m_en[idx], got_rd, exp_rd, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (!done) begin
      check_inst(0, en0, rd0);
      check_inst(1, en1, rd1);
    end
  end

  task automatic wr(input logic s, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; wsel = s; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [31:0] cw(input int src, input int d1, input int d2,
                                     input bit byp, input logic [1:0] g);
    return (32'(d2) << 20) | (32'(d1) << 8) | (32'(byp) << 6) |
           (32'(src) << 4) | 32'(g);
  endfunction

  initial begin
    cur_req = "R1";
    idle(5);
    rst_n = 1'b1;
    idle(3);
    cur_req = "R3/R10";
    wr(1'b0, cw(0, 3, 0, 1'b0, 2'b11)); idle(30);
    cur_req = "R3";
    wr(1'b0, cw(0, 0, 0, 1'b0, 2'b11)); idle(15);
    wr(1'b0, cw(0, 1, 1, 1'b0, 2'b11)); idle(10);
    cur_req = "R4";
    wr(1'b0, cw(0, 2, 3, 1'b0, 2'b11)); idle(40);
    wr(1'b0, cw(0, 5, 4, 1'b0, 2'b01)); idle(60);
    cur_req = "R2";
    wr(1'b0, cw(2, 2, 2, 1'b0, 2'b11)); idle(40);
    wr(1'b0, cw(3, 2, 2, 1'b0, 2'b11)); idle(40);
    wr(1'b0, cw(1, 2, 2, 1'b0, 2'b11)); idle(20);
    cur_req = "R5";
    wr(1'b0, cw(0, 9, 9, 1'b1, 2'b11)); idle(40);
    cur_req = "R6";
    wr(1'b0, cw(0, 7, 2, 1'b0, 2'b11)); idle(9);
    wr(1'b0, cw(0, 7, 2, 1'b0, 2'b10)); idle(5);
    wr(1'b0, cw(0, 4, 2, 1'b0, 2'b11)); idle(3);
    wr(1'b0, cw(0, 4, 3, 1'b0, 2'b11)); idle(30);
    cur_req = "R7";
    wr(1'b0, cw(0, 2, 1, 1'b0, 2'b10)); idle(20);
    wr(1'b0, cw(0, 2, 1, 1'b0, 2'b00)); idle(20);
    cur_req = "R8";
    wr(1'b1, 32'h0000_0001); idle(20);
    wr(1'b1, 32'h0000_0000); idle(20);
    wr(1'b0, cw(0, 2, 1, 1'b0, 2'b11)); idle(20);
    cur_req = "R9";
    wr(1'b1, 32'hA5A5_A5A4); idle(12);
    wr(1'b0, 32'hFC3F_3F3D); idle(20);
    cur_req = "R1";
    rst_n = 1'b0; idle(4);
    rst_n = 1'b1; idle(4);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog expired got running exp finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule